// File: doc/BRIEF.md
# Three-Phase Turn-On Delay Gate Driver Logic

This block sits between a modulator and the gate drivers of a three-phase bridge. Each phase has one logic control input. The block derives a high-side and a low-side gate signal from it, and inserts a fixed guard interval before either switch of a leg is allowed to turn on. A control change turns the conducting switch off as soon as the synchronized control edge is seen. The opposite switch turns on only after a fixed count of clock cycles has elapsed. The count is fixed at build time, so the only way to stretch the guard interval in a system is to slow the block's clock.

The control inputs are asynchronous. Each one passes through a two-stage synchronizer, and every delay is measured from the synchronized edge. The phases run independently. A global enable and a per-phase enable both gate the outputs. Dropping either enable forces the affected gates low at once. Restoring it re-arms the phase through a full guard interval, so a switch is never turned on the instant an enable returns.

Top module: `deadband_gen`

## Requirements
- R1: While `rst` is high all gate outputs are 0. After `rst` falls with a control input held at 0, that phase's low-side output rises on the 8th rising clock edge after the release and not before.
- R2: When a control input rises and then holds, the high-side output of that phase rises exactly 8 clock edges after the synchronized control rises. The synchronizer adds 2 edges, so a change driven between two edges appears at the output 10 edges later.
- R3: When a control input falls and then holds, the low-side output of that phase rises exactly 8 clock edges after the synchronized control falls.
- R4: A gate output that is high falls in the same cycle that the synchronized control changes, which is 2 clock edges after the input change, with no added guard delay.
- R5: Each phase has its own control input, counter and outputs (bit i of every vector belongs to phase i). A change on one phase does not alter the outputs or timing of another phase.
- R6: If a control input reverses before its guard interval ends, the pending turn-on is dropped and neither gate of that phase turns on. A new full interval starts from the reversal.
- R7: While `en_ch[i]` is 0, both gates of phase i are 0 at once. After `en_ch[i]` returns to 1, the gate selected by the control level turns on only on the 8th clock edge after the enable is restored.
- R8: While `en_all` is 0, all gate outputs are 0 at once. After it returns to 1, every enabled phase waits 8 clock edges before turning on.
- R9: The high-side and low-side outputs of one phase are never 1 together, and either one rises only after at least 8 sampled cycles with both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its period sets the guard interval length |
| rst | input | 1 | Synchronous active-high reset |
| ctl_in | input | 3 | Asynchronous control level per phase (1 = high side wanted) |
| en_all | input | 1 | Global output enable, active high |
| en_ch | input | 3 | Per-phase output enable, active high |
| hi_out | output | 3 | High-side gate signals, active high |
| lo_out | output | 3 | Low-side gate signals, active high |

## Verification
The bench samples one cycle before and at the exact turn-on cycle. A design that is off by one edge in its counter preload or synchronizer depth fails one of those two samples. It reverses one control input in the middle of its guard interval; a design that kept the stale countdown would turn on a gate early or turn on the wrong side. Enables are dropped per phase and globally, then restored. A design that restored the gate at once, or that disturbed other phases, shows a gate high where the bench expects 0. A check on every row confirms that no phase ever drives both of its gates high together.

// File: rtl/dt_pkg.sv
package dt_pkg;

    localparam int DEAD_DEFAULT  = 8;
    localparam int SYNC_DEFAULT  = 2;
    localparam int PHASE_DEFAULT = 3;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    function automatic int cnt_width(input int dead);
        return (dead < 1) ? 1 : $clog2(dead + 1);
    endfunction

endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d_async;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/dt_channel.sv
module dt_channel
    import dt_pkg::*;
#(
    parameter int DEAD = DEAD_DEFAULT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    input  logic       en,
    output gate_pair_t gate
);
    localparam int CW = cnt_width(DEAD);
    localparam logic [CW-1:0] FULL_LOAD = CW'(DEAD);
    localparam logic [CW-1:0] EDGE_LOAD = CW'(DEAD - 1);

    logic          lvl_d;
    logic [CW-1:0] cnt;
    logic          settled;

    // Edge cycle: lvl differs from lvl_d, so neither gate is on.
    // The preload of DEAD-1 lands the turn-on DEAD edges after lvl moved.
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_d <= 1'b0;
            cnt   <= FULL_LOAD;
        end else begin
            lvl_d <= lvl;
            if (!en)
                cnt <= FULL_LOAD;
            else if (lvl != lvl_d)
                cnt <= EDGE_LOAD;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    assign settled = (cnt == '0);

    always_comb begin
        gate.hi = en & settled &  lvl &  lvl_d;
        gate.lo = en & settled & ~lvl & ~lvl_d;
    end
endmodule

// File: rtl/deadband_gen.sv
module deadband_gen
    import dt_pkg::*;
#(
    parameter int NUM_CH      = PHASE_DEFAULT,
    parameter int DEAD_CLKS   = DEAD_DEFAULT,
    parameter int SYNC_STAGES = SYNC_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ctl_in,
    input  logic              en_all,
    input  logic [NUM_CH-1:0] en_ch,
    output logic [NUM_CH-1:0] hi_out,
    output logic [NUM_CH-1:0] lo_out
);
    logic [NUM_CH-1:0] sync_lvl;
    logic [NUM_CH-1:0] ch_ok;
    gate_pair_t        gates [NUM_CH];

    dt_sync #(
        .WIDTH (NUM_CH),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst    (rst),
        .d_async(ctl_in),
        .q_sync (sync_lvl)
    );

    assign ch_ok = en_ch & {NUM_CH{en_all}};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_phase
        dt_channel #(
            .DEAD(DEAD_CLKS)
        ) ch_i (
            .clk (clk),
            .rst (rst),
            .lvl (sync_lvl[g]),
            .en  (ch_ok[g]),
            .gate(gates[g])
        );
        assign hi_out[g] = gates[g].hi;
        assign lo_out[g] = gates[g].lo;
    end
endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
    parameter int NUM_CH    = 3,
    parameter int DEAD_CLKS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en_all,
    input logic [NUM_CH-1:0] en_ch,
    input logic [NUM_CH-1:0] sync_lvl,
    input logic [NUM_CH-1:0] hi_out,
    input logic [NUM_CH-1:0] lo_out
);
    localparam int QW = $clog2(DEAD_CLKS + 1);

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
        (hi_out & lo_out) == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        logic [QW-1:0] quiet;

        always_ff @(posedge clk) begin
            if (rst)
                quiet <= '0;
            else if (hi_out[g] | lo_out[g])
                quiet <= '0;
            else if (quiet != QW'(DEAD_CLKS))
                quiet <= quiet + 1'b1;
        end

        p_guard_gap_r2: assert property (@(posedge clk) disable iff (rst)
            ($rose(hi_out[g]) || $rose(lo_out[g])) |-> (quiet >= QW'(DEAD_CLKS)));

        p_follow_level_r4: assert property (@(posedge clk) disable iff (rst)
            (sync_lvl[g] ? !lo_out[g] : !hi_out[g]));

        p_disable_low_r7: assert property (@(posedge clk) disable iff (rst)
            !(en_all && en_ch[g]) |-> (!hi_out[g] && !lo_out[g]));
    end
endmodule

bind deadband_gen dt_checker #(
    .NUM_CH   (NUM_CH),
    .DEAD_CLKS(DEAD_CLKS)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .en_all  (en_all),
    .en_ch   (en_ch),
    .sync_lvl(sync_lvl),
    .hi_out  (hi_out),
    .lo_out  (lo_out)
);

// File: tb/deadband_gen_tb_top.sv
module deadband_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NROW = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ctl_in = 3'b000;
    logic       en_all = 1'b1;
    logic [2:0] en_ch = 3'b111;
    logic [2:0] hi_out, lo_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    deadband_gen dut_i (
        .clk   (clk),
        .rst   (rst),
        .ctl_in(ctl_in),
        .en_all(en_all),
        .en_ch (en_ch),
        .hi_out(hi_out),
        .lo_out(lo_out)
    );

    // fields: ctl[3] en_all[1] en_ch[3] wait[4] exp_hi[3] exp_lo[3] req[4]
    localparam logic [20:0] VEC [NROW] = '{
        {3'b001, 1'b1, 3'b111, 4'd2,  3'b000, 3'b110, 4'd4}, // R4 lo0 drops
        {3'b001, 1'b1, 3'b111, 4'd7,  3'b000, 3'b110, 4'd2}, // R2 one before
        {3'b001, 1'b1, 3'b111, 4'd1,  3'b001, 3'b110, 4'd2}, // R2 turn-on
        {3'b011, 1'b1, 3'b111, 4'd10, 3'b011, 3'b100, 4'd5}, // R5 ch1 alone
        {3'b010, 1'b1, 3'b111, 4'd2,  3'b010, 3'b100, 4'd4}, // R4 hi0 drops
        {3'b010, 1'b1, 3'b111, 4'd7,  3'b010, 3'b100, 4'd3}, // R3 one before
        {3'b010, 1'b1, 3'b111, 4'd1,  3'b010, 3'b101, 4'd3}, // R3 turn-on
        {3'b010, 1'b1, 3'b101, 4'd1,  3'b000, 3'b101, 4'd7}, // R7 ch1 off
        {3'b010, 1'b1, 3'b111, 4'd7,  3'b000, 3'b101, 4'd7}, // R7 still waiting
        {3'b010, 1'b1, 3'b111, 4'd1,  3'b010, 3'b101, 4'd7}, // R7 back on
        {3'b010, 1'b0, 3'b111, 4'd1,  3'b000, 3'b000, 4'd8}, // R8 all off
        {3'b010, 1'b1, 3'b111, 4'd7,  3'b000, 3'b000, 4'd8}, // R8 waiting
        {3'b010, 1'b1, 3'b111, 4'd1,  3'b010, 3'b101, 4'd8}, // R8 back on
        {3'b110, 1'b1, 3'b111, 4'd3,  3'b010, 3'b001, 4'd6}, // R6 lo2 drops
        {3'b010, 1'b1, 3'b111, 4'd9,  3'b010, 3'b001, 4'd6}, // R6 reversed, no hi2
        {3'b010, 1'b1, 3'b111, 4'd1,  3'b010, 3'b101, 4'd6}  // R6 lo2 from reversal
    };

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got hi/lo=%b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            finish_run();
        end
    end

    initial begin
        bit overlap;
        // R1: outputs low during reset
        repeat (3) @(negedge clk);
        check("R1", {hi_out, lo_out}, 6'b000000);
        rst = 1'b0;
        repeat (7) @(negedge clk);
        check("R1", {hi_out, lo_out}, 6'b000000);
        @(negedge clk);
        check("R1", {hi_out, lo_out}, 6'b000111);

        for (int r = 0; r < NROW; r++) begin
            logic [20:0] v;
            v = VEC[r];
            ctl_in = v[20:18];
            en_all = v[17];
            en_ch  = v[16:14];
            overlap = 1'b0;
            for (int w = 0; w < int'(v[13:10]); w++) begin
                @(negedge clk);
                if ((hi_out & lo_out) != 3'b000) overlap = 1'b1;
            end
            check($sformatf("R%0d row %0d", v[3:0], r), {hi_out, lo_out}, v[9:4]);
            check("R9 overlap", {5'b0, overlap}, 6'b0);
        end

        // R1: reset mid-interval clears everything
        ctl_in = 3'b111;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", {hi_out, lo_out}, 6'b000000);

        done = 1'b1;
        finish_run();
    end
endmodule